// File: doc/BRIEF.md
# Dual-Line Edge-Triggered Interrupt Bank

This block gathers up to 24 external event sources and presents them to two independent host interrupt lines, A and B. Each source has a two-bit edge selection field that both lines share. Each line keeps its own status bits and its own mask bits. A source whose selected edge is seen sets its status bit on both lines at once. Each line then acknowledges that bit on its own, either by writing ones to the status byte or, when clear-on-read is enabled, by reading it.

The unmasked status of each line is ORed into a one-bit summary that feeds the next aggregation stage. A registered, active-low copy of the same summary drives that line's interrupt pin. Each status bit buffers one more event that arrives while the bit is already set, and releases it straight after the clear. An event that lands in the same cycle as a clear is never lost. Software reaches all state through a byte-wide register port. Reads are combinational, and writes and read side effects take place at the clock edge.

Top module: `irq2_edge_bank`

## Requirements
- R1: After reset all mask bits read 1, status, edge selection and the control byte read 0, and both interrupt pins are high.
- R2: The edge selection field of source i sits in edge byte i/4 at bit 2*(i mod 4). Its upper bit enables rising edges and its lower bit enables falling edges. A source whose two bits are both 0 never sets status.
- R3: A selected edge on a source, held stable for at least three clocks, sets that source's status bit. The bit becomes readable after the third rising clock edge that follows the input change.
- R4: One detected event sets the status bit on both lines, and a clear on one line leaves the other line's status untouched.
- R5: A mask bit of 1 keeps its source out of that line's summary, and each summary output is the OR of status AND NOT mask for its line.
- R6: Each interrupt pin is registered and active low, and it follows the inverse of its line's summary one clock later.
- R7: With control bit 0 at 0, writing a 1 to a status bit clears it, writing a 0 has no effect, and reading does not clear.
- R8: With control bit 0 at 1, reading a line's status byte returns it and then clears the returned bits, and writes to status bytes have no effect.
- R9: An event that arrives while its status bit is already set is buffered, and it sets the bit again in the cycle after the clear. Only one such event is buffered per bit and line.
- R10: An event detected in the same clock edge as a clear of its bit leaves the bit set.
- R11: The register map is as follows, with multi-byte registers little-endian (lowest source in the lowest byte) and unmapped addresses reading 0:
  - line A status at 0x00–0x02, line A mask at 0x04–0x06;
  - line B status at 0x08–0x0A, line B mask at 0x0C–0x0E;
  - edge selection at 0x10–0x15;
  - control at 0x18, where bit 0 enables clear-on-read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NSRC | Asynchronous event sources |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe, takes effect at the clock edge |
| reg_rd | input | 1 | Read strobe, clear-on-read side effect at the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| sum_a | output | 1 | Line A summary to the primary aggregator |
| sum_b | output | 1 | Line B summary to the primary aggregator |
| irq_a_n | output | 1 | Line A interrupt, active low |
| irq_b_n | output | 1 | Line B interrupt, active low |

## Verification
The properties assume that sources are low while reset is applied, because a source that is high at reset release looks like a rising edge. They also assume that the register port never raises its read and write strobes in the same cycle. The stimulus holds every source level for at least five clocks, releases reset with all sources at 0, and issues every register access from a task that raises exactly one strobe. The clear-versus-event collision is placed on purpose by counting the synchronizer stages, so that the read edge and the detected edge fall on the same clock.

// File: rtl/irq2_edge_bank.sv
module irq2_edge_bank #(
  parameter int NSRC = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic [7:0]      reg_addr,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  output logic            sum_a,
  output logic            sum_b,
  output logic            irq_a_n,
  output logic            irq_b_n
);
  localparam int SB = (NSRC + 7) / 8;
  localparam int EB = (2 * NSRC + 7) / 8;
  localparam int SW = SB * 8;
  localparam int EW = EB * 8;
  localparam logic [SW-1:0] VLD = SW'((64'd1 << NSRC) - 64'd1);
  localparam logic [1:0][7:0] STAT_BASE = {8'h08, 8'h00};
  localparam logic [1:0][7:0] MASK_BASE = {8'h0C, 8'h04};
  localparam logic [7:0] EDGE_BASE = 8'h10;
  localparam logic [7:0] CTRL_ADDR = 8'h18;

  logic [NSRC-1:0]    s1, s2, s3;
  logic [EW-1:0]      edge_cfg;
  logic               cor;
  logic [SW-1:0]      evt;
  logic [1:0][SW-1:0] stat, pend, msk, clr;
  logic [1:0]         irq_q;

  always_comb begin
    evt = '0;
    for (int i = 0; i < NSRC; i++)
      evt[i] = (edge_cfg[2*i+1] & s2[i] & ~s3[i]) | (edge_cfg[2*i] & ~s2[i] & s3[i]);
  end

  always_comb begin
    clr = '0;
    for (int l = 0; l < 2; l++)
      for (int b = 0; b < SB; b++)
        if (reg_addr == 8'(STAT_BASE[l] + b)) begin
          if (reg_rd && cor)       clr[l][8*b +: 8] = stat[l][8*b +: 8];
          else if (reg_wr && !cor) clr[l][8*b +: 8] = reg_wdata;
        end
  end

  always_comb begin
    reg_rdata = '0;
    for (int l = 0; l < 2; l++)
      for (int b = 0; b < SB; b++) begin
        if (reg_addr == 8'(STAT_BASE[l] + b)) reg_rdata = stat[l][8*b +: 8];
        if (reg_addr == 8'(MASK_BASE[l] + b)) reg_rdata = msk[l][8*b +: 8];
      end
    for (int b = 0; b < EB; b++)
      if (reg_addr == 8'(EDGE_BASE + b)) reg_rdata = edge_cfg[8*b +: 8];
    if (reg_addr == CTRL_ADDR) reg_rdata = {7'b0, cor};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
      edge_cfg <= '0;
      cor <= 1'b0;
      stat <= '0;
      pend <= '0;
      msk <= {2{VLD}};
      irq_q <= 2'b11;
    end else begin
      s1 <= src_in; s2 <= s1; s3 <= s2;
      for (int l = 0; l < 2; l++) begin
        stat[l] <= ((stat[l] & ~clr[l]) | evt | (pend[l] & clr[l])) & VLD;
        pend[l] <= ((clr[l] & pend[l] & evt) | (~clr[l] & (pend[l] | (stat[l] & evt)))) & VLD;
        irq_q[l] <= ~|(stat[l] & ~msk[l]);
        if (reg_wr)
          for (int b = 0; b < SB; b++)
            if (reg_addr == 8'(MASK_BASE[l] + b))
              msk[l][8*b +: 8] <= reg_wdata & VLD[8*b +: 8];
      end
      if (reg_wr) begin
        for (int b = 0; b < EB; b++)
          if (reg_addr == 8'(EDGE_BASE + b)) edge_cfg[8*b +: 8] <= reg_wdata;
        if (reg_addr == CTRL_ADDR) cor <= reg_wdata[0];
      end
    end
  end

  assign sum_a   = |(stat[0] & ~msk[0]);
  assign sum_b   = |(stat[1] & ~msk[1]);
  assign irq_a_n = irq_q[0];
  assign irq_b_n = irq_q[1];
endmodule

// File: rtl/irq2_edge_bank_chk.sv
module irq2_edge_bank_chk #(
  parameter int NSRC = 24
) (
  input logic clk,
  input logic rst_n,
  input logic reg_wr,
  input logic reg_rd,
  input logic cor,
  input logic sum_a,
  input logic sum_b,
  input logic irq_a_n,
  input logic irq_b_n,
  input logic [2*(((2*NSRC+7)/8)*4)-1:0] edge_cfg,
  input logic [1:0][((NSRC+7)/8)*8-1:0] stat,
  input logic [1:0][((NSRC+7)/8)*8-1:0] pend
);
  p_irq_lag_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_a_n == !$past(sum_a));
  p_irq_lag_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_b_n == !$past(sum_b));
  p_pend_needs_stat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend[0] & ~stat[0]) == '0) && ((pend[1] & ~stat[1]) == '0));
  p_sticky_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(reg_wr && !cor) && !(reg_rd && cor)) |=>
      ((stat & $past(stat)) == $past(stat)));
  p_quiet_when_unselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_cfg == '0) |=> ((stat[0] & ~$past(stat[0]) & ~$past(pend[0])) == '0));
endmodule

bind irq2_edge_bank irq2_edge_bank_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .cor(cor),
  .sum_a(sum_a), .sum_b(sum_b), .irq_a_n(irq_a_n), .irq_b_n(irq_b_n),
  .edge_cfg(edge_cfg), .stat(stat), .pend(pend)
);

// File: tb/sim_irq2_edge_bank.sv
module sim_irq2_edge_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] src_in = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        sum_a, sum_b, irq_a_n, irq_b_n;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;
  logic [7:0]  d;

  always #4 clk = ~clk;

  irq2_edge_bank #(.NSRC(24)) u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sum_a(sum_a), .sum_b(sum_b), .irq_a_n(irq_a_n), .irq_b_n(irq_b_n)
  );

  // {source[4:0], edge field[1:0], falling stimulus, status expected}
  localparam logic [8:0] VEC [0:8] = '{
    {5'd0,  2'b10, 1'b0, 1'b1},
    {5'd1,  2'b10, 1'b1, 1'b0},
    {5'd5,  2'b01, 1'b1, 1'b1},
    {5'd9,  2'b01, 1'b0, 1'b0},
    {5'd12, 2'b10, 1'b0, 1'b1},
    {5'd14, 2'b11, 1'b0, 1'b1},
    {5'd18, 2'b11, 1'b1, 1'b1},
    {5'd23, 2'b00, 1'b0, 1'b0},
    {5'd23, 2'b00, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] v);
    reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic clear_all();
    repeat (2)
      for (int b = 0; b < 3; b++) begin
        wr(8'(8'h00 + b), 8'hFF);
        wr(8'(8'h08 + b), 8'hFF);
      end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int idx;
    logic [1:0] cfg;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    chk("R1 irq_a_n", {7'b0, irq_a_n}, 8'h01);
    chk("R1 irq_b_n", {7'b0, irq_b_n}, 8'h01);
    rd(8'h04, d); chk("R1 mask A0", d, 8'hFF);
    rd(8'h06, d); chk("R1 mask A2", d, 8'hFF);
    rd(8'h0E, d); chk("R1 mask B2", d, 8'hFF);
    rd(8'h00, d); chk("R1 status A0", d, 8'h00);
    rd(8'h10, d); chk("R1 edge0", d, 8'h00);
    rd(8'h18, d); chk("R1 ctrl", d, 8'h00);

    // R11 map
    rd(8'h03, d); chk("R11 unmapped", d, 8'h00);
    wr(8'h05, 8'h5A); rd(8'h05, d); chk("R11 mask A1", d, 8'h5A);
    wr(8'h05, 8'hFF);

    // R2 R3 R4 edge table
    for (int n = 0; n < 9; n++) begin
      idx = int'(VEC[n][8:4]);
      cfg = VEC[n][3:2];
      for (int b = 0; b < 6; b++) wr(8'(8'h10 + b), 8'h00);
      wr(8'(8'h10 + idx / 4), 8'({6'b0, cfg} << (2 * (idx % 4))));
      if (VEC[n][1]) begin src_in[idx] = 1'b1; tick(5); end
      clear_all();
      src_in[idx] = ~src_in[idx];
      tick(5);
      rd(8'(8'h00 + idx / 8), d);
      chk(cfg == 2'b00 ? "R2 line A" : "R3 line A", d,
          VEC[n][0] ? 8'(8'd1 << (idx % 8)) : 8'h00);
      rd(8'(8'h08 + idx / 8), d);
      chk("R4 line B", d, VEC[n][0] ? 8'(8'd1 << (idx % 8)) : 8'h00);
      src_in[idx] = 1'b0;
      tick(5);
      clear_all();
    end

    // R5 R6 R3 timing, source 3 rising, line A unmasked
    for (int b = 0; b < 6; b++) wr(8'(8'h10 + b), 8'h00);
    wr(8'h10, 8'h80);
    wr(8'h04, 8'hF7);
    clear_all();
    src_in[3] = 1'b1;
    tick(2);
    chk("R3 not yet", {7'b0, sum_a}, 8'h00);
    tick(1);
    chk("R5 sum_a", {7'b0, sum_a}, 8'h01);
    chk("R6 irq lags", {7'b0, irq_a_n}, 8'h01);
    tick(1);
    chk("R6 irq_a_n low", {7'b0, irq_a_n}, 8'h00);
    chk("R5 sum_b masked", {7'b0, sum_b}, 8'h00);
    chk("R5 irq_b_n masked", {7'b0, irq_b_n}, 8'h01);

    // R7 write-one-clear mode
    wr(8'h00, 8'h00);
    rd(8'h00, d); chk("R7 zero write kept", d, 8'h08);
    rd(8'h00, d); chk("R7 read kept", d, 8'h08);
    wr(8'h00, 8'h08);
    chk("R7 cleared", {7'b0, sum_a}, 8'h00);
    chk("R6 irq still low", {7'b0, irq_a_n}, 8'h00);
    tick(1);
    chk("R6 irq released", {7'b0, irq_a_n}, 8'h01);

    // R9 one buffered event
    wr(8'h10, 8'hC0);
    clear_all();
    src_in[3] = 1'b0; tick(5);
    src_in[3] = 1'b1; tick(5);
    src_in[3] = 1'b0; tick(5);
    rd(8'h00, d); chk("R9 set", d, 8'h08);
    wr(8'h00, 8'h08);
    rd(8'h00, d); chk("R9 reloaded", d, 8'h08);
    wr(8'h00, 8'h08);
    rd(8'h00, d); chk("R9 depth one", d, 8'h00);
    clear_all();

    // R8 clear-on-read mode
    wr(8'h18, 8'h01);
    src_in[3] = 1'b1; tick(5);
    wr(8'h00, 8'hFF);
    rd(8'h00, d); chk("R8 write ignored", d, 8'h08);
    rd(8'h00, d); chk("R8 read cleared", d, 8'h00);
    rd(8'h08, d); chk("R4 line B kept", d, 8'h08);
    rd(8'h08, d); chk("R8 line B cleared", d, 8'h00);

    // R10 event on the clearing edge
    src_in[3] = 1'b0; tick(5);
    src_in[3] = 1'b1;
    tick(2);
    rd(8'h00, d); chk("R10 first read", d, 8'h08);
    rd(8'h00, d); chk("R10 not lost", d, 8'h08);
    rd(8'h00, d); chk("R10 then clear", d, 8'h00);

    finish_run();
  end
endmodule